// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Master

This block sits between a synchronous requester and an external asynchronous 32K x 8 static RAM. The requester presents one command at a time, a read or a write with its address and data, through a valid/ready handshake. The block then produces the active-low chip-enable, output-enable and write-enable strobes, keeps the address stable and drives the data bus only for a write. It reports completion with a single-cycle pulse. For a read, the captured byte is presented with that pulse.

Every strobe width, setup and hold is a nanosecond parameter. The block turns each one into a whole number of clock cycles by rounding up, and never uses fewer than one cycle. A read holds chip-enable and output-enable low until the slowest of the address, chip-enable and output-enable access times has passed, then samples the bus. A write keeps output-enable high and uses write-enable as the timing strobe. The write-enable low phase covers the pulse width, the address-to-strobe-high time and the data setup. Chip-enable and the driven data stay active afterwards for the data hold and for any remainder of the minimum cycle time. The data bus leaves the block as a separate output value and enable, so the pad ring builds the tristate.

Top module: `sram_strobe_master`

## Requirements
- R1: While reset is asserted and immediately after it, chip-enable, output-enable and write-enable are high, the data enable is low, the done pulse is low and the block is ready.
- R2: A command is taken only on a clock edge where req_valid and req_ready are both high. req_ready is high only while the block is idle, and a request presented while it is low has no effect on the memory.
- R3: A read holds chip-enable and output-enable low and write-enable high, with the address unchanged, for exactly NRD = max(ceil(T_ADDR_ACC/P), ceil(T_CE_ACC/P), ceil(T_OE_ACC/P), ceil(T_CYCLE/P)) cycles, where P is the clock period in ns. The bus is sampled on the edge that ends this window.
- R4: A write holds output-enable high throughout and write-enable low for exactly NWL = max(ceil(T_WE_WIDTH/P), ceil(T_ADDR_WEH/P), ceil(T_DSETUP/P)) cycles. Chip-enable and write-enable fall on the same edge, so the address setup is zero.
- R5: During a write the data enable is high and the data value and address are constant from the fall of write-enable until chip-enable rises. Chip-enable rises exactly NWH = max(ceil(T_DHOLD/P), ceil(T_CYCLE/P) - NWL, 1) cycles after write-enable rises.
- R6: done is high for exactly one clock per command. In that cycle, for a read, rdata holds the sampled byte.
- R7: Chip-enable stays high for at least one full cycle between two consecutive commands.
- R8: Counting falling clock edges after the accepting rising edge, done is first seen high on edge NRD+1 for a read and on edge NWL+NWH+1 for a write.
- R9: The data enable is never high while output-enable is low, so the block and the memory never drive the bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the command |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | High while idle and able to take a command |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte captured by the last read |
| sram_ce_n | output | 1 | Chip-enable strobe, active low |
| sram_oe_n | output | 1 | Output-enable strobe, active low |
| sram_we_n | output | 1 | Write-enable strobe, active low |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_dq_out | output | DATA_W | Data value driven toward the memory |
| sram_dq_oe | output | 1 | Enable for driving sram_dq_out onto the bus |
| sram_dq_in | input | DATA_W | Data as seen on the memory bus |

## Verification
The bench builds the block with its default parameters: a 5 ns clock, a 70 ns cycle and access time, a 35 ns output-enable access, and write timing of 50/60/30/5 ns. These give a 14-cycle read, a 12-cycle write-enable pulse and a 2-cycle write tail. The tail comes from the cycle-time remainder, not from the 5 ns hold, so both terms of the hold formula are reached. The memory model drives the complemented byte until its own 70 ns access count has elapsed, so an early sample returns a visibly wrong value. Its strobe-length counters catch a window that is one cycle too short or too long.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WHOLD = 3'd3,
    ST_REC   = 3'd4
  } seq_state_e;

  // Round a time up to whole clock periods, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    int unsigned c;
    c = (ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Read window: slowest access path, stretched to the cycle time.
  function automatic int unsigned rd_cycles(input int unsigned per, input int unsigned t_aa,
                                            input int unsigned t_ce, input int unsigned t_oe,
                                            input int unsigned t_cyc);
    return max2(max2(ns_to_cyc(t_aa, per), ns_to_cyc(t_ce, per)),
                max2(ns_to_cyc(t_oe, per), ns_to_cyc(t_cyc, per)));
  endfunction

  // Write-enable low phase: pulse width, address to strobe high, data setup.
  function automatic int unsigned wl_cycles(input int unsigned per, input int unsigned t_wp,
                                            input int unsigned t_aw, input int unsigned t_ds);
    return max2(ns_to_cyc(t_wp, per), max2(ns_to_cyc(t_aw, per), ns_to_cyc(t_ds, per)));
  endfunction

  // Tail after write-enable rises: data hold, or what the cycle time still needs.
  function automatic int unsigned wh_cycles(input int unsigned per, input int unsigned t_dh,
                                            input int unsigned t_cyc, input int unsigned n_wl);
    int unsigned cyc;
    int unsigned rest;
    cyc  = ns_to_cyc(t_cyc, per);
    rest = (cyc > n_wl) ? (cyc - n_wl) : 1;
    return max2(ns_to_cyc(t_dh, per), rest);
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CW  = 4,
  parameter int NRD = 14,
  parameter int NWL = 12,
  parameter int NWH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          expire,
  output logic          req_ready,
  output logic          accept,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cap_en,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic          done
);
  localparam logic [CW-1:0] LD_RD = CW'(NRD - 1);
  localparam logic [CW-1:0] LD_WL = CW'(NWL - 1);
  localparam logic [CW-1:0] LD_WH = CW'(NWH - 1);

  seq_state_e state_q;
  logic       rd_last;
  logic       wl_last;
  logic       wh_last;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (state_q == ST_RD)    && expire;
  assign wl_last   = (state_q == ST_WLOW)  && expire;
  assign wh_last   = (state_q == ST_WHOLD) && expire;
  assign cap_en    = rd_last;
  assign tmr_load  = accept || wl_last;

  always_comb begin
    if (wl_last)        tmr_val = LD_WH;
    else if (req_write) tmr_val = LD_WL;
    else                tmr_val = LD_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ce_n <= 1'b0;
            if (req_write) begin
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              state_q <= ST_WLOW;
            end else begin
              oe_n    <= 1'b0;
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (rd_last) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_REC;
          end
        end
        ST_WLOW: begin
          if (wl_last) begin
            we_n    <= 1'b1;
            state_q <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          if (wh_last) begin
            ce_n    <= 1'b1;
            dq_oe   <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_REC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rdata       <= '0;
    end else begin
      if (accept) begin
        sram_addr <= req_addr;
        if (req_write) sram_dq_out <= req_wdata;
      end
      if (cap_en) rdata <= sram_dq_in;
    end
  end
endmodule

// File: rtl/sram_strobe_master.sv
`timescale 1ns/1ps
module sram_strobe_master
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 5,
  parameter int T_CYCLE_NS     = 70,
  parameter int T_ADDR_ACC_NS  = 70,
  parameter int T_CE_ACC_NS    = 70,
  parameter int T_OE_ACC_NS    = 35,
  parameter int T_WE_WIDTH_NS  = 50,
  parameter int T_ADDR_WEH_NS  = 60,
  parameter int T_DSETUP_NS    = 30,
  parameter int T_DHOLD_NS     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int NRD  = rd_cycles(CLK_PERIOD_NS, T_ADDR_ACC_NS, T_CE_ACC_NS, T_OE_ACC_NS, T_CYCLE_NS);
  localparam int NWL  = wl_cycles(CLK_PERIOD_NS, T_WE_WIDTH_NS, T_ADDR_WEH_NS, T_DSETUP_NS);
  localparam int NWH  = wh_cycles(CLK_PERIOD_NS, T_DHOLD_NS, T_CYCLE_NS, NWL);
  localparam int NMAX = max2(NRD, max2(NWL, NWH));
  localparam int CW   = $clog2(NMAX + 1);

  logic          accept;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          expire;
  logic          cap_en;

  sram_cyc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  sram_seq_fsm #(.CW(CW), .NRD(NRD), .NWL(NWL), .NWH(NWH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expire    (expire),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cap_en    (cap_en),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe),
    .done      (done)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .cap_en      (cap_en),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .rdata       (rdata)
  );
endmodule

// File: rtl/sram_strobe_master_chk.sv
`timescale 1ns/1ps
module sram_strobe_master_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr
);
  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n));

  p_drive_inside_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !sram_ce_n);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(sram_ce_n));

  p_ce_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |=> sram_ce_n);

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
endmodule

bind sram_strobe_master sram_strobe_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe),
  .sram_addr  (sram_addr)
);

// File: tb/sram_strobe_master_test.sv
`timescale 1ns/1ps
module sram_strobe_master_test;
  localparam real PER = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [14:0] sram_addr;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in = 8'h00;

  int n_run = 0;
  int n_fail = 0;
  int n_rd, n_wl, n_wh, n_acc;

  always #2.5 clk = ~clk;

  sram_strobe_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rdata(rdata), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // Timing conversion restated with real arithmetic.
  function automatic int cyc(input real ns);
    int c;
    c = int'($ceil(ns / PER));
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] init_val(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory model with timing checks ----------------
  logic [7:0] mem [int];
  logic [7:0] sb  [int];
  int rd_cnt = 0, we_lo = 0, hold_cnt = 0, ce_lo = 0, ce_hi = 0;
  bit in_hold = 0, cyc_wr = 0, contention = 0;
  logic [14:0] w_adr, prev_adr;
  logic [7:0]  w_dat;

  function automatic logic [7:0] mem_get(input logic [14:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return init_val(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe && !sram_oe_n) contention = 1;
      // read access timer: restarts on address change
      if (!sram_ce_n && !sram_oe_n && sram_we_n && (rd_cnt == 0 || sram_addr == prev_adr))
        rd_cnt++;
      else
        rd_cnt = 0;
      prev_adr = sram_addr;
      sram_dq_in = (rd_cnt >= n_acc) ? mem_get(sram_addr) : ~mem_get(sram_addr);
      // write strobe tracking
      if (!sram_ce_n && !sram_we_n) begin
        if (we_lo == 0) begin
          w_adr = sram_addr; w_dat = sram_dq_out; cyc_wr = 1;
        end else if (sram_addr != w_adr || sram_dq_out != w_dat || !sram_dq_oe || !sram_oe_n) begin
          chk(0, "R5 data/addr/oe during WE low", int'(sram_dq_out), int'(w_dat));
        end
        we_lo++;
      end else if (we_lo > 0) begin
        chk(we_lo == n_wl, "R4 WE low cycles", we_lo, n_wl);
        mem[int'(w_adr)] = w_dat;
        in_hold = 1; hold_cnt = 0; we_lo = 0;
      end
      if (in_hold) begin
        if (!sram_ce_n) begin
          hold_cnt++;
          if (!sram_dq_oe || sram_dq_out != w_dat || sram_addr != w_adr)
            chk(0, "R5 data hold", int'(sram_dq_out), int'(w_dat));
        end else begin
          chk(hold_cnt == n_wh, "R5 hold cycles", hold_cnt, n_wh);
          in_hold = 0;
        end
      end
      // chip-enable windows
      if (!sram_ce_n) begin
        if (ce_lo == 0) chk(ce_hi >= 1, "R7 CE high gap", ce_hi, 1);
        ce_lo++; ce_hi = 0;
      end else begin
        if (ce_lo > 0) begin
          if (cyc_wr) chk(ce_lo == n_wl + n_wh, "R8 write CE window", ce_lo, n_wl + n_wh);
          else        chk(ce_lo == n_rd, "R3 read CE window", ce_lo, n_rd);
        end
        ce_lo = 0; cyc_wr = 0; ce_hi++;
      end
    end
  end

  // ---------------- command tasks ----------------
  task automatic start_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (wr) sb[int'(a)] = d;
  endtask

  task automatic finish_op(input bit wr, input logic [14:0] a, input int already);
    int lat;
    logic [7:0] exp;
    lat = already;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == (wr ? n_wl + n_wh + 1 : n_rd + 1), "R8 latency", lat, wr ? n_wl + n_wh + 1 : n_rd + 1);
    if (!wr) begin
      exp = sb.exists(int'(a)) ? sb[int'(a)] : init_val(a);
      chk(rdata == exp, "R3 R6 read data", int'(rdata), int'(exp));
    end
    @(negedge clk);
    chk(!done, "R6 done single cycle", int'(done), 0);
  endtask

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    start_op(wr, a, d);
    finish_op(wr, a, 1);
  endtask

  task automatic summary;
    chk(!contention, "R9 bus contention", int'(contention), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(PER * 150000.0);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_acc = imax(cyc(70.0), cyc(35.0));
    n_rd  = imax(n_acc, cyc(70.0));
    n_wl  = imax(imax(cyc(50.0), cyc(60.0)), cyc(30.0));
    n_wh  = imax(cyc(5.0), imax(cyc(70.0) - n_wl, 1));
    void'($urandom(32'h5EED));

    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes in reset",
        int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
    chk(!sram_dq_oe && !done, "R1 drive/done in reset", int'({sram_dq_oe, done}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // directed: extremes, write then read back, read of unwritten cell
    do_op(0, 15'h1234, 8'h00);
    do_op(1, 15'h0000, 8'hA5);
    do_op(1, 15'h7FFF, 8'h3C);
    do_op(0, 15'h0000, 8'h00);
    do_op(0, 15'h7FFF, 8'h00);
    do_op(1, 15'h0000, 8'hFF);
    do_op(0, 15'h0000, 8'h00);

    // R2: requests presented while busy are ignored
    start_op(1, 15'h0200, 8'h33);
    req_valid = 1; req_write = 1; req_addr = 15'h0300; req_wdata = 8'h5A;
    for (int i = 0; i < 5; i++) begin
      chk(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
    finish_op(1, 15'h0200, 6);
    do_op(0, 15'h0300, 8'h00);
    do_op(0, 15'h0200, 8'h00);

    // random mix
    for (int i = 0; i < 150; i++) begin
      bit wr;
      logic [14:0] a;
      int sel;
      wr  = 1'($urandom % 2);
      sel = int'($urandom % 4);
      a   = (sel == 0) ? 15'h0000 : (sel == 1) ? 15'h7FFF : 15'($urandom % 16);
      do_op(wr, a, 8'($urandom));
    end
    summary();
  end
endmodule